// File: doc/BRIEF.md
# PCIe Memory Window Address Translator

This block sits between the receive side of a PCIe endpoint and its local memory-mapped fabric. For each incoming memory request it takes the system address, which can be up to 64 bits wide, and checks it against up to six configurable address windows. Each window has a base, a power-of-two size, an enable, and a 32-/64-bit type. An even slot marked 64-bit joins with the odd slot above it to form one 64-bit window. When a window matches, the block forwards the address bits below that window's size boundary unchanged as a 32-bit local byte address. It also raises the one-hot select of the local master port that belongs to the window.

A root-port mode turns matching off. In that mode every request goes to master port 0 with its low address bits intact. Results are registered, one cycle after the request.

The result is held in a small state register with four named states. `ST_IDLE` means no request was taken last cycle. `ST_HIT` means a window matched. `ST_MISS` means no window matched. `ST_ROOT` means the request was forwarded in root-port mode. Every clock makes one transition, chosen from the current inputs:
- no valid request → `ST_IDLE`
- valid request with root mode → `ST_ROOT`
- valid request with a match → `ST_HIT`
- any other valid request → `ST_MISS`

Reset forces `ST_IDLE`.

Top module: `bar_xlate`

## Requirements
- R1: Each of the six slots has an enable bit (`cfg_en[i]`). A disabled slot never matches.
- R2: When `cfg_is64[i]` is set on an even slot i that has a slot i+1, window i uses the base of slot i+1 as bits 63:32 and the base of slot i as bits 31:0. While slot i is enabled and 64-bit, slot i+1 is never matched on its own. The 64-bit flag on an odd slot, or on the last slot, is ignored, and that slot acts as a 32-bit window.
- R3: The window size is 2^s, where s is the slot's 6-bit `cfg_log2sz` field. Values below 12 act as 12. Only address bits s and above are compared against the base, and base bits below s are ignored.
- R4: On a hit, `out_addr` holds the request address bits below s unchanged. Bits at s and above are zero. The field is truncated to 32 bits.
- R5: On a hit of slot i, `out_sel` has only bit i set and `out_bar` equals i.
- R6: In root mode every valid request gives a hit on master port 0: `out_sel` = 1 and `out_bar` = 0. `out_addr` holds the low 32 bits of the request address, and no window is consulted.
- R7: When `in_is64` is 0, bits 63:32 of `in_addr` are ignored and treated as zero. Such a request can therefore hit a 64-bit window only if that window's upper base is zero. A 32-bit window never matches an address whose bits 63:32 are nonzero.
- R8: When several windows match, the lowest-numbered slot wins.
- R9: A valid request that matches nothing gives `out_miss` = 1 and `out_hit` = 0, with `out_sel`, `out_bar` and `out_addr` all zero.
- R10: Outputs appear one clock after `in_valid`. A clock without `in_valid` gives `out_valid` = 0, and every other output is zero.
- R11: An active-low synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| root_mode | input | 1 | Forward all requests to port 0 without matching |
| in_valid | input | 1 | Request present this cycle |
| in_is64 | input | 1 | Request carries a 64-bit address |
| in_addr | input | 64 | Request system address |
| cfg_en | input | NUM_BARS | Per-slot enable |
| cfg_is64 | input | NUM_BARS | Per-slot 64-bit type (even slots only) |
| cfg_base | input | 32*NUM_BARS | Per-slot 32-bit base, slot i at bits 32i+31:32i |
| cfg_log2sz | input | 6*NUM_BARS | Per-slot log2 of window size, slot i at bits 6i+5:6i |
| out_valid | output | 1 | Result valid |
| out_hit | output | 1 | A window (or root mode) accepted the request |
| out_miss | output | 1 | No window matched |
| out_bar | output | $clog2(NUM_BARS) | Index of the winning slot |
| out_sel | output | NUM_BARS | One-hot local master port select |
| out_addr | output | 32 | Local byte address |

## Verification
Each request is mapped to its result one cycle later, with nothing carried between requests. A wrong result state, a wrong winner or a wrong mask therefore shows up in exactly the next cycle's `out_hit`, `out_miss`, `out_sel` or `out_addr`. A reference model compares every field on every clock.

The directed cases cover:
- pairs of 64-bit slots and suppression of the upper slot;
- the size clamp and the size boundary;
- 32-bit requests carrying junk upper bits;
- overlapping windows;
- root mode;
- reset in the middle of traffic.

Randomised traffic aimed at the configured bases then exercises mixed hits and misses.

// File: rtl/bar_xlate_pkg.sv
package bar_xlate_pkg;
    localparam int SYS_AW    = 64;
    localparam int BASE_W    = 32;
    localparam int LOG2_W    = 6;
    localparam int MIN_LOG2  = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2,
        ST_ROOT = 2'd3
    } xl_state_e;

    function automatic logic [LOG2_W-1:0] clamp_log2(input logic [LOG2_W-1:0] raw);
        return (raw < LOG2_W'(MIN_LOG2)) ? LOG2_W'(MIN_LOG2) : raw;
    endfunction
endpackage

// File: rtl/bar_slot_match.sv
module bar_slot_match
    import bar_xlate_pkg::*;
#(
    parameter int IDX      = 0,
    parameter int NUM_BARS = 6,
    parameter int LOC_AW   = 32
) (
    input  logic [SYS_AW-1:0] eff_addr,
    input  logic [BASE_W-1:0] base_lo,
    input  logic [BASE_W-1:0] base_hi,
    input  logic [LOG2_W-1:0] log2sz,
    input  logic              en,
    input  logic              is64,
    input  logic              claimed,
    output logic              hit,
    output logic [LOC_AW-1:0] loc_addr
);
    localparam bit CAN_PAIR = ((IDX % 2) == 0) && ((IDX + 1) < NUM_BARS);

    logic [LOG2_W-1:0] sz;
    logic [SYS_AW-1:0] keep_hi;
    logic [SYS_AW-1:0] base_full;
    logic              wide;

    always_comb begin
        sz        = clamp_log2(log2sz);
        keep_hi   = ~((SYS_AW'(1) << sz) - SYS_AW'(1));
        wide      = CAN_PAIR && is64;
        base_full = wide ? {base_hi, base_lo} : {{(SYS_AW-BASE_W){1'b0}}, base_lo};
        hit       = en && !claimed && (((eff_addr ^ base_full) & keep_hi) == '0);
        loc_addr  = eff_addr[LOC_AW-1:0] & ~keep_hi[LOC_AW-1:0];
    end
endmodule

// File: rtl/bar_prio_pick.sv
module bar_prio_pick #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
        any    = |hits;
        onehot = hits & (~hits + N'(1));
    end
endmodule

// File: rtl/bar_xlate.sv
module bar_xlate
    import bar_xlate_pkg::*;
#(
    parameter int NUM_BARS = 6,
    parameter int LOC_AW   = 32,
    localparam int BAR_IW  = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       root_mode,
    input  logic                       in_valid,
    input  logic                       in_is64,
    input  logic [SYS_AW-1:0]          in_addr,
    input  logic [NUM_BARS-1:0]        cfg_en,
    input  logic [NUM_BARS-1:0]        cfg_is64,
    input  logic [NUM_BARS*BASE_W-1:0] cfg_base,
    input  logic [NUM_BARS*LOG2_W-1:0] cfg_log2sz,
    output logic                       out_valid,
    output logic                       out_hit,
    output logic                       out_miss,
    output logic [BAR_IW-1:0]          out_bar,
    output logic [NUM_BARS-1:0]        out_sel,
    output logic [LOC_AW-1:0]          out_addr
);
    logic [SYS_AW-1:0]   eff_addr;
    logic [NUM_BARS-1:0] slot_hit;
    logic [LOC_AW-1:0]   slot_loc [NUM_BARS];
    logic                any_hit;
    logic [BAR_IW-1:0]   win_idx;
    logic [NUM_BARS-1:0] win_sel;

    xl_state_e           state_q, state_d;
    logic [BAR_IW-1:0]   bar_q, bar_d;
    logic [NUM_BARS-1:0] sel_q, sel_d;
    logic [LOC_AW-1:0]   addr_q, addr_d;

    assign eff_addr = in_is64 ? in_addr : {{(SYS_AW-32){1'b0}}, in_addr[31:0]};

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_slot
        logic [BASE_W-1:0] hi_base;
        logic              taken;
        if ((g + 1) < NUM_BARS) begin : g_hi
            assign hi_base = cfg_base[(g+1)*BASE_W +: BASE_W];
        end else begin : g_nohi
            assign hi_base = '0;
        end
        if ((g % 2) == 1) begin : g_odd
            assign taken = cfg_en[g-1] && cfg_is64[g-1];
        end else begin : g_even
            assign taken = 1'b0;
        end
        bar_slot_match #(.IDX(g), .NUM_BARS(NUM_BARS), .LOC_AW(LOC_AW)) u_match (
            .eff_addr (eff_addr),
            .base_lo  (cfg_base[g*BASE_W +: BASE_W]),
            .base_hi  (hi_base),
            .log2sz   (cfg_log2sz[g*LOG2_W +: LOG2_W]),
            .en       (cfg_en[g]),
            .is64     (cfg_is64[g]),
            .claimed  (taken),
            .hit      (slot_hit[g]),
            .loc_addr (slot_loc[g])
        );
    end

    bar_prio_pick #(.N(NUM_BARS), .IW(BAR_IW)) u_pick (
        .hits   (slot_hit),
        .any    (any_hit),
        .idx    (win_idx),
        .onehot (win_sel)
    );

    // Next-state and next-result selection
    always_comb begin
        state_d = ST_IDLE;
        bar_d   = '0;
        sel_d   = '0;
        addr_d  = '0;
        if (in_valid) begin
            if (root_mode) begin
                state_d = ST_ROOT;
                sel_d   = NUM_BARS'(1);
                addr_d  = eff_addr[LOC_AW-1:0];
            end else if (any_hit) begin
                state_d = ST_HIT;
                bar_d   = win_idx;
                sel_d   = win_sel;
                addr_d  = slot_loc[win_idx];
            end else begin
                state_d = ST_MISS;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bar_q   <= '0;
            sel_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            bar_q   <= bar_d;
            sel_q   <= sel_d;
            addr_q  <= addr_d;
        end
    end

    // Output decode
    always_comb begin
        out_valid = 1'b0;
        out_hit   = 1'b0;
        out_miss  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HIT, ST_ROOT: begin
                out_valid = 1'b1;
                out_hit   = 1'b1;
            end
            ST_MISS: begin
                out_valid = 1'b1;
                out_miss  = 1'b1;
            end
            default: ;
        endcase
        out_bar  = bar_q;
        out_sel  = sel_q;
        out_addr = addr_q;
    end

    p_one_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_sel) && (out_hit == (out_sel != '0)));
    p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_miss |-> (out_sel == '0 && out_addr == '0 && out_bar == '0));
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && (out_hit != out_miss)));
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_hit && !out_miss && out_sel == '0));
    p_root_port0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && root_mode) |=> (out_hit && out_sel == NUM_BARS'(1) && out_bar == '0));
endmodule

// File: tb/bar_xlate_tb.sv
module bar_xlate_tb;
    localparam int NB = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_is64 = 1'b0;
    logic [63:0] in_addr = '0;
    logic [NB-1:0] cfg_en = '0;
    logic [NB-1:0] cfg_is64 = '0;
    logic [31:0] base_a [NB];
    logic [5:0]  lg_a [NB];
    logic [NB*32-1:0] cfg_base;
    logic [NB*6-1:0]  cfg_log2sz;
    logic        out_valid, out_hit, out_miss;
    logic [2:0]  out_bar;
    logic [NB-1:0] out_sel;
    logic [31:0] out_addr;

    int errors = 0;
    int checks = 0;

    logic        e_valid, e_hit, e_miss;
    logic [2:0]  e_bar;
    logic [NB-1:0] e_sel;
    logic [31:0] e_addr;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            cfg_base[i*32 +: 32]  = base_a[i];
            cfg_log2sz[i*6 +: 6]  = lg_a[i];
        end
    end

    bar_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .root_mode(root_mode), .in_valid(in_valid),
        .in_is64(in_is64), .in_addr(in_addr), .cfg_en(cfg_en), .cfg_is64(cfg_is64),
        .cfg_base(cfg_base), .cfg_log2sz(cfg_log2sz), .out_valid(out_valid),
        .out_hit(out_hit), .out_miss(out_miss), .out_bar(out_bar),
        .out_sel(out_sel), .out_addr(out_addr)
    );

    // Behavioural reference: result of the inputs currently applied
    task automatic compute();
        longint unsigned a, b;
        int sz;
        e_valid = 0; e_hit = 0; e_miss = 0; e_bar = 0; e_sel = 0; e_addr = 0;
        if (!rst_n || !in_valid) return;
        a = in_is64 ? in_addr : {32'h0, in_addr[31:0]};
        e_valid = 1;
        if (root_mode) begin
            e_hit = 1; e_sel = 1; e_addr = a[31:0];
            return;
        end
        for (int i = 0; i < NB; i++) begin
            if (!cfg_en[i]) continue;
            if ((i % 2) == 1 && cfg_en[i-1] && cfg_is64[i-1]) continue;
            if (cfg_is64[i] && (i % 2) == 0 && i + 1 < NB) b = {base_a[i+1], base_a[i]};
            else b = {32'h0, base_a[i]};
            sz = (lg_a[i] < 12) ? 12 : int'(lg_a[i]);
            if ((a >> sz) == (b >> sz)) begin
                e_hit = 1; e_bar = 3'(i); e_sel = NB'(1) << i;
                e_addr = (sz >= 32) ? a[31:0] : (a[31:0] & ((32'h1 << sz) - 32'h1));
                return;
            end
        end
        e_miss = 1;
    endtask

    task automatic compare(input string tag);
        checks++;
        if ({out_valid, out_hit, out_miss, out_bar, out_sel, out_addr} !==
            {e_valid, e_hit, e_miss, e_bar, e_sel, e_addr}) begin
            errors++;
            $display("FAIL %s: got v=%0b h=%0b m=%0b bar=%0d sel=%b addr=%h, expected v=%0b h=%0b m=%0b bar=%0d sel=%b addr=%h",
                tag, out_valid, out_hit, out_miss, out_bar, out_sel, out_addr,
                e_valid, e_hit, e_miss, e_bar, e_sel, e_addr);
        end
    endtask

    task automatic step(input string tag, input logic v, input logic w, input logic [63:0] ad);
        in_valid = v; in_is64 = w; in_addr = ad;
        compute();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic clear_cfg();
        cfg_en = '0; cfg_is64 = '0;
        for (int i = 0; i < NB; i++) begin base_a[i] = '0; lg_a[i] = 6'd12; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_cfg();
        in_valid = 1'b1; in_addr = 64'h1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compute();
        compare("R11 reset state");
        rst_n = 1'b1;

        step("R10 idle", 0, 0, 64'h0);

        // 32-bit window in slot 2, 64 KB
        base_a[2] = 32'h8000_0000; lg_a[2] = 6'd16; cfg_en[2] = 1;
        step("R4 R5 hit slot 2", 1, 0, 64'h8000_1234);
        step("R9 miss", 1, 0, 64'h9000_1234);
        cfg_en[2] = 0;
        step("R1 disabled slot", 1, 0, 64'h8000_1234);
        cfg_en[2] = 1;
        step("R7 32-bit window vs upper bits", 1, 1, 64'h0000_0002_8000_0010);
        step("R7 upper bits ignored on 32-bit request", 1, 0, 64'hDEAD_0000_8000_0010);

        // 64-bit pair in slots 0/1
        base_a[0] = 32'h4000_0000; base_a[1] = 32'h1; cfg_is64[0] = 1; cfg_en[0] = 1; cfg_en[1] = 1;
        step("R2 pair hit", 1, 1, 64'h0000_0001_4000_0ABC);
        step("R2 pair miss without upper", 1, 1, 64'h0000_0000_4000_0ABC);
        step("R2 upper slot suppressed", 1, 0, 64'h50);
        base_a[1] = 32'h0;
        step("R7 32-bit request to 64-bit window", 1, 0, 64'hBEEF_0000_4000_0010);

        // overlap: slots 2 and 3 both cover the address
        clear_cfg();
        base_a[2] = 32'h2000_0000; lg_a[2] = 6'd20; cfg_en[2] = 1;
        base_a[3] = 32'h2000_0000; lg_a[3] = 6'd12; cfg_en[3] = 1;
        step("R8 lowest wins", 1, 0, 64'h2000_0040);
        step("R3 bit 19 inside window", 1, 0, 64'h2008_0040);
        step("R3 bit 20 outside window", 1, 0, 64'h2010_0040);

        clear_cfg();
        base_a[4] = 32'h0000_3000; lg_a[4] = 6'd4; cfg_en[4] = 1;
        step("R3 size clamp", 1, 0, 64'h0000_3F00);
        cfg_is64[3] = 1; cfg_en[3] = 1; base_a[3] = 32'h0000_3000;
        step("R2 odd 64-bit flag ignored", 1, 0, 64'h0000_3F00);
        cfg_is64[5] = 1; cfg_en[5] = 1; base_a[5] = 32'h7000_0000;
        step("R2 last slot 64-bit flag ignored", 1, 0, 64'h7000_0123);

        root_mode = 1;
        step("R6 root mode", 1, 1, 64'hFFFF_0000_ABCD_1234);
        step("R6 root idle", 0, 0, 64'h0);
        root_mode = 0;

        step("R10 back to back a", 1, 0, 64'h0000_3010);
        step("R10 back to back b", 1, 0, 64'h0000_9010);
        step("R10 then idle", 0, 0, 64'h0000_3010);

        rst_n = 0;
        step("R11 reset mid-traffic", 1, 0, 64'h0000_3010);
        rst_n = 1;

        for (int n = 0; n < 400; n++) begin
            logic [63:0] ad;
            int s;
            if (n % 25 == 0) begin
                for (int i = 0; i < NB; i++) begin
                    base_a[i] = $urandom & 32'hF0FF_F000;
                    lg_a[i]   = 6'(8 + ($urandom % 24));
                end
                cfg_en = NB'($urandom); cfg_is64 = NB'($urandom);
                root_mode = (($urandom % 8) == 0);
            end
            s = $urandom % NB;
            ad = {($urandom % 4 == 0) ? 32'($urandom) : base_a[(s+1) % NB], base_a[s] ^ (32'($urandom) & 32'h0010_FFFF)};
            step("R5 R8 random", ($urandom % 6) != 0, $urandom % 2, ad);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule